// File: doc/BRIEF.md
# Opcode-Synchronized Reset Pulse Generator

This block drives the active-low system reset of an 8-bit processor whose program also refreshes dynamic memory. When power becomes good, reset is held asserted for a fixed number of clocks and then released so the processor starts. A second, longer power-up interval must also pass before manual reset requests are accepted. Any stray request raised in that interval is discarded.

After power-up, the manual reset switch never drives the reset line directly. The switch level is first synchronized and debounced. A debounced closure arms a flag on the next falling edge of the active-low opcode-fetch strobe. The rising edge of that flag fires a one-shot. The one-shot pulls reset low for a fixed, short number of cycles that begins in step with the fetch. The processor is therefore never held in reset long enough to lose memory refresh, and no memory access is cut off part way through.

Holding the switch closed gives exactly one pulse. A new pulse needs the switch to open and then close again. All delays are counted in clock cycles. The pulse width is derived from the clock frequency and a width in microseconds.

Top module: `opfetch_reset_gen`

## Requirements
- R1: While `por_n` is sampled low at a rising clock edge, `rst_n` is 0 after that edge.
- R2: After `por_n` goes high, `rst_n` stays 0 until the (RELEASE_CYC+1)-th rising edge with `por_n` high, and is 1 after that edge.
- R3: Until CLEAR_CYC cycles have passed since `por_n` went high, no manual reset pulse is produced, even if the switch is closed and fetch strobes occur.
- R4: `sw_closed` (1 = closed, 0 = open) is synchronized and must be stable for DEBOUNCE_CYC consecutive cycles to count. A closure shorter than that never produces a pulse.
- R5: With the switch debounced closed, a fetch edge on `m1_n` (1 sampled at one edge, 0 at the next) leaves `rst_n` at 1 after that edge. `rst_n` is 0 after the following edge.
- R6: Every manual reset pulse keeps `rst_n` at 0 for exactly PULSE_CYC cycles (PULSE_US microseconds at CLK_HZ; 32 cycles by default), far below one millisecond.
- R7: While the switch stays closed, any number of fetch edges produce exactly one pulse.
- R8: After the switch has opened (debounced) and closed again, the next fetch edge produces a new pulse.
- R9: A closure with no fetch edge on `m1_n` produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Power-good, active low; synchronous block reset and start of power-up timing |
| sw_closed | input | 1 | Raw manual reset switch level, 1 when closed |
| m1_n | input | 1 | Active-low opcode-fetch strobe from the processor |
| rst_n | output | 1 | Active-low system reset |

## Verification
The main function is driven by closures of the switch that differ in length and in the density of fetch strobes inside them. A long closure with frequent strobes separates a one-pulse-per-closure design from one that retriggers. A closure with no strobe separates fetch-synchronized arming from direct switch reset. A closure shorter than the debounce window separates a filtered switch from a raw one. Back-to-back closures show that the arm clears on opening. Directed cases pin the exact edge where the pulse starts and ends relative to the strobe, the power-up release edge, and the rule that strobes during the early power-up interval do not arm.

// File: rtl/rstgen_pkg.sv
// Shared types and helpers for the opcode-synchronized reset generator.
// Assumes integer clock frequencies that are a multiple of 1 MHz.
package rstgen_pkg;

    // Debounced switch state
    typedef enum logic {
        SW_OPEN   = 1'b0,
        SW_CLOSED = 1'b1
    } sw_level_e;

    // Convert a width in microseconds into clock cycles, never below one
    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned us);
        int unsigned cyc;
        cyc = (clk_hz / 1_000_000) * us;
        return (cyc == 0) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/rstgen_sw_filter.sv
// Switch conditioner: brings the raw switch level into the clock domain through
// a SYNC_STAGES-deep flop chain. It then accepts a new level only after that
// level has been seen on DEBOUNCE_CYC consecutive edges.
// Assumes: por_n is synchronous to clk; DEBOUNCE_CYC >= 1.
module rstgen_sw_filter
    import rstgen_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned DEBOUNCE_CYC = 16
) (
    input  logic      clk,
    input  logic      por_n,
    input  logic      sw_raw,
    output sw_level_e sw_state
);

    localparam int unsigned DW = $clog2(DEBOUNCE_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic [DW-1:0]          db_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_single
            // Single-stage capture of the switch level
            always_ff @(posedge clk) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= sw_raw;
            end
        end else begin : g_sync_chain
            // Shift the switch level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sw_raw};
            end
        end
    endgenerate

    assign sync_out = sync_q[SYNC_STAGES-1];

    // Count consecutive disagreement and flip the accepted level when it lasts
    always_ff @(posedge clk) begin
        if (!por_n) begin
            db_cnt   <= '0;
            sw_state <= SW_OPEN;
        end else if (sync_out != logic'(sw_state)) begin
            if (db_cnt == DW'(DEBOUNCE_CYC - 1)) begin
                db_cnt   <= '0;
                sw_state <= sw_level_e'(sync_out);
            end else begin
                db_cnt <= db_cnt + 1'b1;
            end
        end else begin
            db_cnt <= '0;
        end
    end

endmodule

// File: rtl/rstgen_por_timer.sv
// Power-up timer: counts cycles since por_n went high, saturating at CLEAR_CYC.
// "released" allows the reset line to go high; "cleared" allows manual arming.
// Assumes: CLEAR_CYC > RELEASE_CYC >= 1.
module rstgen_por_timer #(
    parameter int unsigned RELEASE_CYC = 64,
    parameter int unsigned CLEAR_CYC   = 128
) (
    input  logic clk,
    input  logic por_n,
    output logic released,
    output logic cleared
);

    localparam int unsigned PW = $clog2(CLEAR_CYC + 1);

    logic [PW-1:0] up_cnt;

    // Saturating count of cycles with power good
    always_ff @(posedge clk) begin
        if (!por_n)                        up_cnt <= '0;
        else if (up_cnt != PW'(CLEAR_CYC)) up_cnt <= up_cnt + 1'b1;
    end

    assign released = (up_cnt >= PW'(RELEASE_CYC));
    assign cleared  = (up_cnt == PW'(CLEAR_CYC));

endmodule

// File: rtl/rstgen_arm_oneshot.sv
// Arming flag and one-shot. The flag is set by a falling edge of m1_n while the
// debounced switch is closed. It is cleared while the switch is open or before
// the power-up clear time. Its rising edge loads a PULSE_CYC down-counter.
// pulse_next is 1 when the reset line should be low after the coming edge.
// Assumes: m1_n comes from logic clocked by clk.
module rstgen_arm_oneshot
    import rstgen_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 32
) (
    input  logic      clk,
    input  logic      por_n,
    input  logic      cleared,
    input  sw_level_e sw_state,
    input  logic      m1_n,
    output logic      pulse_next
);

    localparam int unsigned CW = $clog2(PULSE_CYC + 1);

    logic          m1_prev;
    logic          m1_fall;
    logic          armed_q;
    logic          armed_d;
    logic          fire;
    logic [CW-1:0] pulse_cnt;

    // Remember the previous fetch-strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!por_n) m1_prev <= 1'b1;
        else        m1_prev <= m1_n;
    end

    assign m1_fall = m1_prev && !m1_n;

    // Arm on a fetch edge while closed; disarm while open or too early
    always_ff @(posedge clk) begin
        if (!por_n)                               armed_q <= 1'b0;
        else if (!cleared || sw_state == SW_OPEN) armed_q <= 1'b0;
        else if (m1_fall)                         armed_q <= 1'b1;
    end

    // Delayed copy of the flag so only its rising edge fires
    always_ff @(posedge clk) begin
        if (!por_n) armed_d <= 1'b0;
        else        armed_d <= armed_q;
    end

    assign fire = armed_q && !armed_d;

    // One-shot width counter, loaded on the flag's rising edge
    always_ff @(posedge clk) begin
        if (!por_n)              pulse_cnt <= '0;
        else if (fire)           pulse_cnt <= CW'(PULSE_CYC);
        else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
    end

    assign pulse_next = fire || (pulse_cnt > CW'(1));

endmodule

// File: rtl/opfetch_reset_gen.sv
// Top level: system reset generator. Reset is held after power-up for
// RELEASE_CYC cycles. After that, a manual switch closure yields one pulse of
// PULSE_CYC cycles that starts on the edge after a falling edge of the
// opcode-fetch strobe.
// Assumes: all inputs except sw_closed are synchronous to clk.
module opfetch_reset_gen
    import rstgen_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 4_000_000,
    parameter int unsigned PULSE_US     = 8,
    parameter int unsigned RELEASE_CYC  = 64,
    parameter int unsigned CLEAR_CYC    = 128,
    parameter int unsigned DEBOUNCE_CYC = 16,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic sw_closed,
    input  logic m1_n,
    output logic rst_n
);

    localparam int unsigned PULSE_CYC = us_to_cycles(CLK_HZ, PULSE_US);

    sw_level_e sw_state;
    logic      released;
    logic      cleared;
    logic      pulse_next;
    logic      rst_q;

    rstgen_sw_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .DEBOUNCE_CYC (DEBOUNCE_CYC)
    ) u_sw (
        .clk      (clk),
        .por_n    (por_n),
        .sw_raw   (sw_closed),
        .sw_state (sw_state)
    );

    rstgen_por_timer #(
        .RELEASE_CYC (RELEASE_CYC),
        .CLEAR_CYC   (CLEAR_CYC)
    ) u_por (
        .clk      (clk),
        .por_n    (por_n),
        .released (released),
        .cleared  (cleared)
    );

    rstgen_arm_oneshot #(
        .PULSE_CYC (PULSE_CYC)
    ) u_shot (
        .clk        (clk),
        .por_n      (por_n),
        .cleared    (cleared),
        .sw_state   (sw_state),
        .m1_n       (m1_n),
        .pulse_next (pulse_next)
    );

    // Registered reset output: low before release and during a pulse
    always_ff @(posedge clk) begin
        if (!por_n) rst_q <= 1'b0;
        else        rst_q <= released && !pulse_next;
    end

    assign rst_n = rst_q;

endmodule

// File: rtl/rstgen_chk.sv
// Checker for opcode-synchronized reset generation, bound to the top module.
// It keeps its own power-up cycle count and low-run count from the ports.
module rstgen_chk #(
    parameter int unsigned RELEASE_CYC = 64,
    parameter int unsigned CLEAR_CYC   = 128,
    parameter int unsigned PULSE_CYC   = 32
) (
    input logic clk,
    input logic por_n,
    input logic m1_n,
    input logic rst_n
);

    int unsigned up_cnt;
    int unsigned low_run;

    // Cycles since power good, saturating past the clear time
    always_ff @(posedge clk) begin
        if (!por_n)                    up_cnt <= 0;
        else if (up_cnt <= CLEAR_CYC)  up_cnt <= up_cnt + 1;
    end

    // Length of the current low run of reset after power-up release
    always_ff @(posedge clk) begin
        if (!por_n || rst_n)                                       low_run <= 0;
        else if (up_cnt > RELEASE_CYC && low_run <= PULSE_CYC)     low_run <= low_run + 1;
    end

    // R1
    por_hold_chk: assert property (@(posedge clk) !por_n |=> !rst_n);

    // R2
    release_wait_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |-> up_cnt > RELEASE_CYC);

    // R3
    no_early_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_n) && $past(por_n)) |-> up_cnt > CLEAR_CYC);

    // R5
    fetch_align_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_n) && $past(por_n)) |-> (!$past(m1_n, 2) && $past(m1_n, 3)));

    // R6
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
        low_run <= PULSE_CYC);

    // R6
    pulse_exact_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(rst_n) && low_run != 0) |-> low_run == PULSE_CYC);

endmodule

bind opfetch_reset_gen rstgen_chk #(
    .RELEASE_CYC (RELEASE_CYC),
    .CLEAR_CYC   (CLEAR_CYC),
    .PULSE_CYC   (PULSE_CYC)
) u_chk (
    .clk   (clk),
    .por_n (por_n),
    .m1_n  (m1_n),
    .rst_n (rst_n)
);

// File: tb/opfetch_reset_gen_test.sv
// Bench for opfetch_reset_gen with default parameters.
module opfetch_reset_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int REL   = 64;
    localparam int CLR   = 128;
    localparam int DEB   = 16;
    localparam int PULSE = 32;   // 8 us at 4 MHz

    typedef struct packed {
        int closed_len;
        int m1_period;
        int exp_pulses;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{200, 10, 1},   // R7: long hold, many fetches, one pulse
        '{10,  3,  0},   // R4: closure shorter than debounce
        '{150, 0,  0},   // R9: closed but no fetch edge
        '{120, 7,  1},   // R8: fresh closure after opening
        '{300, 4,  1}    // R7: dense fetches, still one pulse
    };

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sw_closed = 1'b0;
    logic m1_n = 1'b1;
    logic rst_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic prev_r = 1'b0;
    bit   mon_en = 1'b0;
    int   pulses = 0;
    int   cur_low = 0;
    int   last_width = 0;

    opfetch_reset_gen uut (
        .clk       (clk),
        .por_n     (por_n),
        .sw_closed (sw_closed),
        .m1_n      (m1_n),
        .rst_n     (rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pulse monitor sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (!rst_n) cur_low++;
            if (prev_r && !rst_n) pulses++;
            if (!prev_r && rst_n && cur_low > 0) begin
                last_width = cur_low;
                cur_low = 0;
            end
        end
        prev_r = rst_n;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        // R1: reset state while power is not good
        tick(3);
        check(rst_n == 1'b0, "R1", int'(rst_n), 0);

        // R2: release edge; switch closed during power-up for R3
        por_n = 1'b1;
        sw_closed = 1'b1;
        tick(REL);
        check(rst_n == 1'b0, "R2", int'(rst_n), 0);
        tick(1);
        check(rst_n == 1'b1, "R2", int'(rst_n), 1);

        // R3: fetch edges before the clear time do not arm
        mon_en = 1'b1;
        base = pulses;
        for (int i = 0; i < 50; i++) begin
            m1_n = (i % 5 == 4) ? 1'b0 : 1'b1;
            tick(1);
        end
        m1_n = 1'b1;
        check(pulses == base, "R3", pulses - base, 0);
        sw_closed = 1'b0;
        tick(CLR);
        check(pulses == base && rst_n == 1'b1, "R3", pulses - base, 0);

        // Vector table: closures of varying length and fetch density
        for (int v = 0; v < NV; v++) begin
            base = pulses;
            last_width = 0;
            sw_closed = 1'b1;
            for (int i = 0; i < VECS[v].closed_len; i++) begin
                m1_n = (VECS[v].m1_period > 0 &&
                        (i % VECS[v].m1_period) == VECS[v].m1_period - 1) ? 1'b0 : 1'b1;
                tick(1);
            end
            m1_n = 1'b1;
            sw_closed = 1'b0;
            tick(DEB + PULSE + 10);
            // R4 R7 R8 R9: pulse count per closure
            check(pulses - base == VECS[v].exp_pulses, "R4/R7/R8/R9",
                  pulses - base, VECS[v].exp_pulses);
            if (VECS[v].exp_pulses == 1)
                // R6: width of each pulse
                check(last_width == PULSE, "R6", last_width, PULSE);
        end

        // R5 and R6: exact edges of a pulse relative to the fetch edge
        sw_closed = 1'b1;
        tick(DEB + 6);
        m1_n = 1'b0;
        tick(1);
        m1_n = 1'b1;
        check(rst_n == 1'b1, "R5", int'(rst_n), 1);
        tick(1);
        check(rst_n == 1'b0, "R5", int'(rst_n), 0);
        tick(PULSE - 1);
        check(rst_n == 1'b0, "R6", int'(rst_n), 0);
        tick(1);
        check(rst_n == 1'b1, "R6", int'(rst_n), 1);
        sw_closed = 1'b0;
        tick(DEB + 10);

        // R1: power loss during operation
        mon_en = 1'b0;
        por_n = 1'b0;
        tick(2);
        check(rst_n == 1'b0, "R1", int'(rst_n), 0);

        finish_run();
    end

endmodule